// File: doc/BRIEF.md
# Timer Event Flag and Interrupt Enable Register

This block collects the compare and capture events of three 16-bit timer channels into one 8-bit CPU-visible register. Each channel owns a counter that advances while its run input is high and a general register that holds either a compare value or the last captured counter value, selected by a per-channel mode input. A compare match or a captured rising edge on the channel's pin sets a sticky event flag. Each flag has an enable bit beside it, and the channel's interrupt request is the AND of the two.

Software sees flags and enables through a strobe interface: `rd_en` marks a register read, and `wr_en` with `wr_data` writes it. A flag cannot be set by software. Clearing it needs a two-step handshake: a read that returns the flag as 1, then a write of 0 to that bit. A DMA engine serving a channel's request may also clear the flag with a one-cycle acknowledge pulse. The general registers can be preloaded through `gr_load`/`gr_value` and are visible on `gr_out`.

Top module: `tmr_evt_flags`

## Requirements
- R1: `rd_data` always shows the register. Bit 4+i holds the enable of channel i and bit i holds the flag of channel i, for i = 0, 1, 2.
- R2: Bits 7 and 3 of `rd_data` always read 1. Writes to them change nothing.
- R3: During reset every flag and enable is 0 (`rd_data` = 0x88), `irq` is 0, every counter is 0 and every general register is 0xFFFF.
- R4: `irq[i]` is 1 exactly when flag i and enable i are both 1. While the enable is 0 the flag still sets.
- R5: A write loads bits 6:4 into the enables. A 1 written to a flag bit has no effect.
- R6: In compare mode (`cap_mode[i]` = 0), flag i is 1 at the clock after any cycle in which counter i equals general register i.
- R7: A write with bit i at 0 clears flag i only when a read strobe that saw flag i at 1 came before it, with no write in between.
- R8: Any write cancels every pending read permission, including a write that clears nothing.
- R9: A pulse on `dma_ack[i]` clears flag i at the next clock.
- R10: When a set event and any clear fall in the same cycle, the flag ends at 1.
- R11: In capture mode (`cap_mode[i]` = 1), a rising edge on `cap_pin[i]` passes a two-flop synchronizer. Three clocks after the pin rises, general register i holds the counter value and flag i is set. A falling edge does nothing.
- R12: Counter i increments by one per clock while `run[i]` is 1, holds otherwise, and wraps from 0xFFFF to 0.
- R13: `gr_load[i]` writes `gr_value` into general register i. A capture in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 3 | Per-channel counter run |
| cap_mode | input | 3 | Per-channel mode: 1 capture, 0 compare |
| cap_pin | input | 3 | Asynchronous capture inputs |
| gr_load | input | 3 | Per-channel general register load strobe |
| gr_value | input | 16 | Value loaded by `gr_load` |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| dma_ack | input | 3 | Per-channel DMA activation acknowledge |
| rd_data | output | 8 | Register contents |
| irq | output | 3 | Per-channel interrupt requests |
| gr_out | output | 48 | General registers, channel i at bits 16*i+15:16*i |

## Verification
Set-wins is the hardest case to reach: a set event must land in the same cycle as a clear. The bench loads a general register with the stopped counter's own value, so the compare event repeats on every cycle. A DMA acknowledge, and then an armed software clear, are applied during that window. Counter wrap also needs a channel to run for more than 65,536 clocks before a capture shows the small wrapped count. The read-then-write handshake is tested with a disarming write placed between the read and the clearing write.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
    localparam int REG_W   = 8;
    localparam int EN_BASE = 4;
    localparam int SYNC_N  = 3;
endpackage

// File: rtl/tmr_evt_chan.sv
module tmr_evt_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          cap_mode,
    input  logic          cap_pin,
    input  logic          gr_load,
    input  logic [CW-1:0] gr_value,
    output logic          set_evt,
    output logic [CW-1:0] gr_o
);
    import tmr_evt_pkg::*;

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [CW-1:0]     gr;
        logic [SYNC_N-1:0] sync;
    } chan_t;

    chan_t st_d, st_q;
    logic  rise;
    logic  cap_hit;
    logic  cmp_hit;

    always_comb begin
        st_d    = st_q;
        rise    = st_q.sync[1] & ~st_q.sync[2];
        cap_hit = cap_mode & rise;
        cmp_hit = ~cap_mode & (st_q.cnt == st_q.gr);
        set_evt = cap_hit | cmp_hit;
        if (run) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (cap_hit) begin
            st_d.gr = st_q.cnt;
        end else if (gr_load) begin
            st_d.gr = gr_value;
        end
        st_d.sync = {st_q.sync[1], st_q.sync[0], cap_pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.gr   <= '1;
            st_q.sync <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gr_o = st_q.gr;
endmodule

// File: rtl/tmr_evt_regs.sv
module tmr_evt_regs #(
    parameter int NCH = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic                         wr_en,
    input  logic [tmr_evt_pkg::REG_W-1:0] wr_data,
    input  logic [NCH-1:0]               set_evt,
    input  logic [NCH-1:0]               dma_ack,
    output logic [NCH-1:0]               flag_o,
    output logic [NCH-1:0]               en_o
);
    import tmr_evt_pkg::*;

    typedef struct packed {
        logic [NCH-1:0] flag;
        logic [NCH-1:0] en;
        logic [NCH-1:0] arm;
    } regs_t;

    regs_t          st_d, st_q;
    logic [NCH-1:0] clr;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NCH; i++) begin
            clr[i]       = dma_ack[i] | (wr_en & ~wr_data[i] & st_q.arm[i]);
            st_d.flag[i] = set_evt[i] | (st_q.flag[i] & ~clr[i]);
            if (wr_en) begin
                st_d.arm[i] = 1'b0;
                st_d.en[i]  = wr_data[EN_BASE+i];
            end else if (rd_en && st_q.flag[i]) begin
                st_d.arm[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign en_o   = st_q.en;
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags #(
    parameter int NCH = 3,
    parameter int CW  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCH-1:0]                run,
    input  logic [NCH-1:0]                cap_mode,
    input  logic [NCH-1:0]                cap_pin,
    input  logic [NCH-1:0]                gr_load,
    input  logic [CW-1:0]                 gr_value,
    input  logic                          rd_en,
    input  logic                          wr_en,
    input  logic [tmr_evt_pkg::REG_W-1:0] wr_data,
    input  logic [NCH-1:0]                dma_ack,
    output logic [tmr_evt_pkg::REG_W-1:0] rd_data,
    output logic [NCH-1:0]                irq,
    output logic [NCH*CW-1:0]             gr_out
);
    import tmr_evt_pkg::*;

    logic [NCH-1:0] set_evt;
    logic [NCH-1:0] flag;
    logic [NCH-1:0] en;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        tmr_evt_chan #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run[c]),
            .cap_mode (cap_mode[c]),
            .cap_pin  (cap_pin[c]),
            .gr_load  (gr_load[c]),
            .gr_value (gr_value),
            .set_evt  (set_evt[c]),
            .gr_o     (gr_out[c*CW +: CW])
        );
    end

    tmr_evt_regs #(.NCH(NCH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .set_evt (set_evt),
        .dma_ack (dma_ack),
        .flag_o  (flag),
        .en_o    (en)
    );

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (b < NCH) begin : g_flag
            assign rd_data[b] = flag[b];
        end else if (b >= EN_BASE && b < EN_BASE + NCH) begin : g_en
            assign rd_data[b] = en[b-EN_BASE];
        end else begin : g_pad
            assign rd_data[b] = 1'b1;
        end
    end

    assign irq = flag & en;
endmodule

// File: rtl/tmr_evt_flags_chk.sv
module tmr_evt_flags_chk #(
    parameter int NCH = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [tmr_evt_pkg::REG_W-1:0] wr_data,
    input logic [NCH-1:0]                dma_ack,
    input logic [NCH-1:0]                set_evt,
    input logic [tmr_evt_pkg::REG_W-1:0] rd_data,
    input logic [NCH-1:0]                irq
);
    import tmr_evt_pkg::*;

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_data[EN_BASE+i] |-> !irq[i]);
        assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rd_data[i]) |-> $past(set_evt[i]));
        assert_clear_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rd_data[i]) |-> $past(dma_ack[i] || (wr_en && !wr_data[i])));
        assert_dma_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (dma_ack[i] && !set_evt[i]) |=> !rd_data[i]);
        assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> rd_data[i]);
    end
endmodule

bind tmr_evt_flags tmr_evt_flags_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .dma_ack (dma_ack),
    .set_evt (set_evt),
    .rd_data (rd_data),
    .irq     (irq)
);

// File: tb/tmr_evt_flags_test.sv
module tmr_evt_flags_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  run = '0, cap_mode = '0, cap_pin = '0, gr_load = '0, dma_ack = '0;
    logic [15:0] gr_value = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [2:0]  irq;
    logic [47:0] gr_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    int m_cnt[3], m_gr[3], m_p1[3], m_p2[3], m_p3[3], m_flag[3], m_en[3], m_arm[3];

    tmr_evt_flags uut (
        .clk(clk), .rst_n(rst_n), .run(run), .cap_mode(cap_mode), .cap_pin(cap_pin),
        .gr_load(gr_load), .gr_value(gr_value), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .dma_ack(dma_ack), .rd_data(rd_data), .irq(irq), .gr_out(gr_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Behavioural reference, advanced on every rising edge from the inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_cnt[i] = 0; m_gr[i] = 65535; m_p1[i] = 0; m_p2[i] = 0; m_p3[i] = 0;
                m_flag[i] = 0; m_en[i] = 0; m_arm[i] = 0;
            end
        end else begin
            for (int i = 0; i < 3; i++) begin
                bit capt, hit, kill;
                capt = cap_mode[i] && m_p2[i] == 1 && m_p3[i] == 0;
                hit  = capt || (!cap_mode[i] && m_cnt[i] == m_gr[i]);
                kill = dma_ack[i] || (wr_en && !wr_data[i] && m_arm[i] == 1);
                if (hit) m_flag[i] = 1;
                else if (kill) m_flag[i] = 0;
                if (wr_en) m_arm[i] = 0;
                else if (rd_en && m_flag[i] == 1 && !hit && !kill) m_arm[i] = 1;
                if (wr_en) m_en[i] = wr_data[4+i];
                if (capt) m_gr[i] = m_cnt[i];
                else if (gr_load[i]) m_gr[i] = gr_value;
                if (run[i]) m_cnt[i] = (m_cnt[i] + 1) % 65536;
                m_p3[i] = m_p2[i]; m_p2[i] = m_p1[i]; m_p1[i] = cap_pin[i];
            end
        end
    end

    // The arming above must use the flag before this edge; keep a pre-edge copy.
    int pre_flag[3];
    always @(negedge clk) for (int i = 0; i < 3; i++) pre_flag[i] = m_flag[i];
    always @(posedge clk) if (rst_n) begin
        for (int i = 0; i < 3; i++)
            if (!wr_en && rd_en && pre_flag[i] == 1) m_arm[i] = 1;
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            logic [7:0] e_rd;
            logic [2:0] e_irq;
            e_rd = 8'h88;
            for (int i = 0; i < 3; i++) begin
                e_rd[i]   = m_flag[i][0];
                e_rd[4+i] = m_en[i][0];
                e_irq[i]  = m_flag[i][0] & m_en[i][0];
                chk(gr_out[i*16 +: 16] == m_gr[i][15:0], "R13 gr_out", gr_out[i*16 +: 16], m_gr[i]);
            end
            chk(rd_data == e_rd, "R1 rd_data", rd_data, e_rd);
            chk(irq == e_irq, "R4 irq", irq, e_irq);
        end
        if (cycles > 150000 && !done) begin
            chk(1'b0, "watchdog", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_read();
        rd_en = 1'b1; tick(1); rd_en = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v; tick(1); wr_en = 1'b0;
    endtask

    task automatic load_gr(input int c, input logic [15:0] v);
        gr_load[c] = 1'b1; gr_value = v; tick(1); gr_load[c] = 1'b0;
    endtask

    initial begin
        tick(3);
        chk(rd_data == 8'h88, "R3 reset register", rd_data, 8'h88);
        chk(irq == 3'b000, "R3 reset irq", irq, 0);
        chk(gr_out == {48{1'b1}}, "R3 reset gr", gr_out[15:0], 16'hFFFF);
        rst_n = 1'b1;
        tick(2);

        // R2 / R5: write ones everywhere, flags and pad bits unaffected
        reg_write(8'hFF);
        chk(rd_data == 8'hF8, "R5 write ones", rd_data, 8'hF8);
        reg_write(8'h00);
        chk(rd_data == 8'h88, "R2 pad bits stay 1", rd_data, 8'h88);

        // R6: compare on channel 0 while its enable is off
        load_gr(0, 16'd5);
        run[0] = 1'b1; tick(20); run[0] = 1'b0;
        chk(rd_data[0] == 1'b1, "R6 compare flag", rd_data[0], 1);
        chk(irq[0] == 1'b0, "R4 no irq with enable off", irq[0], 0);
        reg_write(8'h10);
        chk(irq[0] == 1'b1, "R4 irq once enabled", irq[0], 1);
        chk(rd_data[0] == 1'b1, "R7 zero write without read", rd_data[0], 1);

        // R8: disarming write between read and clear
        reg_read();
        reg_write(8'h17);
        reg_write(8'h10);
        chk(rd_data[0] == 1'b1, "R8 write disarms", rd_data[0], 1);
        reg_read();
        reg_write(8'h10);
        chk(rd_data == 8'h98, "R7 armed clear", rd_data, 8'h98);
        chk(irq[0] == 1'b0, "R7 irq drops", irq[0], 0);

        // R10: stopped counter 1 equals its general register -> event every cycle
        load_gr(1, 16'd0);
        tick(1);
        dma_ack[1] = 1'b1; tick(1); dma_ack[1] = 1'b0;
        chk(rd_data[1] == 1'b1, "R10 set beats dma clear", rd_data[1], 1);
        reg_read();
        reg_write(8'h00);
        chk(rd_data[1] == 1'b1, "R10 set beats armed clear", rd_data[1], 1);
        load_gr(1, 16'hFFFF);
        tick(2);
        chk(rd_data[1] == 1'b1, "R6 flag sticky", rd_data[1], 1);
        dma_ack[1] = 1'b1; tick(1); dma_ack[1] = 1'b0;
        chk(rd_data[1] == 1'b0, "R9 dma clear", rd_data[1], 0);

        // R11: capture on channel 2
        cap_mode[2] = 1'b1; run[2] = 1'b1;
        tick(10);
        cap_pin[2] = 1'b1;
        tick(2);
        chk(rd_data[2] == 1'b0, "R11 synchronizer delay", rd_data[2], 0);
        tick(1);
        chk(rd_data[2] == 1'b1, "R11 capture flag", rd_data[2], 1);
        chk(gr_out[47:32] != 16'hFFFF, "R11 captured value", gr_out[47:32], m_gr[2]);
        tick(3);
        dma_ack[2] = 1'b1; tick(1); dma_ack[2] = 1'b0;
        cap_pin[2] = 1'b0;
        tick(6);
        chk(rd_data[2] == 1'b0, "R11 falling edge ignored", rd_data[2], 0);

        // R12: channel 1 runs through 0xFFFF and wraps
        run[1] = 1'b1;
        tick(65540);
        chk(rd_data[1] == 1'b1, "R12 compare at 0xFFFF", rd_data[1], 1);
        cap_mode[1] = 1'b1;
        cap_pin[1] = 1'b1;
        tick(5);
        chk(gr_out[31:16] < 16'd64, "R12 wrapped count captured", gr_out[31:16], m_gr[1]);
        cap_pin[1] = 1'b0;
        tick(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule